// File: doc/BRIEF.md
# Extended Control Register Bank with Test FIFO

This block is the extended register bank of an enhanced parallel port, reached at an address window above the port's base registers. Through a byte-wide register bus with a three-bit offset it exposes a control register with an operating-mode field and two FIFO status bits, a configuration byte, and one data location. That data location is either a plain storage byte or the access point of a small byte FIFO, depending on the mode.

When the mode field selects FIFO-test, a write to the data location pushes a byte and a read pops one. In every other mode the same location is an ordinary byte register. Any control-register write that changes the mode empties the FIFO. The current mode is also driven on a dedicated output so that neighbouring logic can follow it.

Reads are combinational: `rd_data` follows `addr` in the same cycle. The side effect of a read, a FIFO pop, takes place at the clock edge that ends a cycle with `rd_en` high.

Top module: `xcr_bank`

## Requirements
- R1: After reset the mode is 0 (compatibility), the FIFO pointers are zero, the FIFO flags read 01 (empty), and offsets 0, 1 and 2 read 0x00, 0x00 and 0x01.
- R2: A write to offset 2 replaces the mode field (bits 7:5) and bits 4:2 with the written value. Written bits 1:0 are ignored. `mode_o` shows the new mode from the next cycle.
- R3: A write to offset 2 whose bits 7:5 differ from the current mode sets both FIFO pointers to zero and the flags to 01 (empty). A write that keeps the same mode leaves the FIFO and its flags unchanged.
- R4: In FIFO-test mode (mode 6), a write to offset 0 stores the byte at the write pointer and advances the pointer. When the pointer reaches the depth (2) it wraps to zero and the flags become 10 (full). Otherwise the flags become 00 (some data).
- R5: In FIFO-test mode, offset 0 reads the byte at the read pointer. With `rd_en` high the pointer advances and wraps at the depth. The flags then become 01 if the read pointer equals the write pointer, and 00 otherwise.
- R6: Outside FIFO-test mode, offset 0 is a plain read/write byte register. Accesses to it leave the FIFO and its flags unchanged.
- R7: Offset 1 is a read/write configuration byte.
- R8: Offsets 3 to 7 read 0xFF, and writes to them change no register.
- R9: A read of any offset other than offset 0 in FIFO-test mode changes no state.
- R10: The flag field (offset 2, bits 1:0) never holds 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the current cycle |
| rd_en | input | 1 | Read strobe; triggers a pop in FIFO-test mode at offset 0 |
| addr | input | 3 | Register offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| mode_o | output | 3 | Current mode field |

## Verification
The assertions assume that the bus never raises `wr_en` and `rd_en` in the same cycle. One of them checks this, and the bench only ever drives a single strobe per cycle. They also assume that `addr` and `wr_data` are stable from the falling edge to the rising edge, so the bench changes them only just after a falling edge. The FIFO properties take no position on overrun or underrun: pushing into a full FIFO and popping an empty one are legal sequences with defined pointer results. The stimulus drives both on purpose so that the wraparound rules are exercised.

// File: rtl/xcr_pkg.sv
package xcr_pkg;
   typedef enum logic [2:0] {
      MD_COMPAT  = 3'd0,
      MD_BYTE    = 3'd1,
      MD_PPFIFO  = 3'd2,
      MD_ECPFIFO = 3'd3,
      MD_EPP     = 3'd4,
      MD_RSVD    = 3'd5,
      MD_FTEST   = 3'd6,
      MD_CONFIG  = 3'd7
   } xcr_mode_e;

   localparam logic [1:0] FL_SOME  = 2'b00;
   localparam logic [1:0] FL_EMPTY = 2'b01;
   localparam logic [1:0] FL_FULL  = 2'b10;

   localparam logic [2:0] OFS_DATA = 3'd0;
   localparam logic [2:0] OFS_CFGB = 3'd1;
   localparam logic [2:0] OFS_CTRL = 3'd2;
endpackage

// File: rtl/xcr_byte_reg.sv
module xcr_byte_reg #(
   parameter int          W   = 8,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= d;
   end

   // R7
   byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));
endmodule

// File: rtl/xcr_fifo.sv
module xcr_fifo
   import xcr_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DEPTH = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] head,
   output logic [1:0]    flags
);
   localparam int          PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
   localparam bit          POW2 = ((1 << PW) == DEPTH);

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_nx, rp_nx;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("xcr_fifo: DEPTH must be at least 2");
      end
      if (POW2) begin : g_wrap_natural
         assign wp_nx = wp + PW'(1);
         assign rp_nx = rp + PW'(1);
      end else begin : g_wrap_cmp
         assign wp_nx = (wp == LAST) ? '0 : wp + PW'(1);
         assign rp_nx = (rp == LAST) ? '0 : rp + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (push) begin
         mem[wp] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         flags <= FL_EMPTY;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         flags <= FL_EMPTY;
      end else if (push) begin
         wp    <= wp_nx;
         flags <= (wp == LAST) ? FL_FULL : FL_SOME;
      end else if (pop) begin
         rp    <= rp_nx;
         flags <= (rp_nx == wp) ? FL_EMPTY : FL_SOME;
      end
   end

   assign head = mem[rp];

   // R10
   flag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags != 2'b11);
   // R4
   push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !flush && wp == LAST) |=> (flags == FL_FULL && wp == '0));
   // R3
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (flags == FL_EMPTY && wp == '0 && rp == '0));
   // R5
   pop_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !flush) |=> flags != FL_FULL);
endmodule

// File: rtl/xcr_ctrl.sv
module xcr_ctrl
   import xcr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [5:0] d_hi,
   output logic [2:0] mode,
   output logic [2:0] mid,
   output logic       change
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= MD_COMPAT;
         mid  <= '0;
      end else if (we) begin
         mode <= d_hi[5:3];
         mid  <= d_hi[2:0];
      end
   end

   assign change = we && (d_hi[5:3] != mode);

   // R2
   mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (mode == $past(d_hi[5:3]) && mid == $past(d_hi[2:0])));
endmodule

// File: rtl/xcr_bank.sv
module xcr_bank
   import xcr_pkg::*;
#(
   parameter int          DW       = 8,
   parameter int          AW       = 3,
   parameter int          DEPTH    = 2,
   parameter logic [7:0]  CFGB_RST = 8'h00
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data,
   output logic [2:0]    mode_o
);
   localparam logic [DW-1:0] UNMAPPED = '1;

   generate
      if (DW != 8) begin : g_bad_dw
         $error("xcr_bank: control layout needs DW == 8");
      end
      if (AW != 3) begin : g_bad_aw
         $error("xcr_bank: offset decode needs AW == 3");
      end
   endgenerate

   logic          sel_data, sel_cfgb, sel_ctrl, in_test;
   logic          push, pop, flush;
   logic [2:0]    mode, mid;
   logic [1:0]    flags;
   logic [DW-1:0] head, data_q, cfgb_q;

   assign sel_data = (addr == OFS_DATA);
   assign sel_cfgb = (addr == OFS_CFGB);
   assign sel_ctrl = (addr == OFS_CTRL);
   assign in_test  = (mode == MD_FTEST);

   assign push = wr_en && sel_data && in_test;
   assign pop  = rd_en && !wr_en && sel_data && in_test;

   xcr_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (wr_en && sel_ctrl),
      .d_hi   (wr_data[7:2]),
      .mode   (mode),
      .mid    (mid),
      .change (flush)
   );

   xcr_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (push),
      .pop   (pop),
      .wdata (wr_data),
      .head  (head),
      .flags (flags)
   );

   xcr_byte_reg #(.W(DW), .RST('0)) u_data (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en && sel_data && !in_test),
      .d     (wr_data),
      .q     (data_q)
   );

   xcr_byte_reg #(.W(DW), .RST(CFGB_RST)) u_cfgb (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en && sel_cfgb),
      .d     (wr_data),
      .q     (cfgb_q)
   );

   always_comb begin
      unique case (addr)
         OFS_DATA: rd_data = in_test ? head : data_q;
         OFS_CFGB: rd_data = cfgb_q;
         OFS_CTRL: rd_data = {mode, mid, flags};
         default:  rd_data = UNMAPPED;
      endcase
   end

   assign mode_o = mode;

   // bus rule assumed by all properties below
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && rd_en));
   // R8
   upper_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr > OFS_CTRL) |=>
         ($stable(mode) && $stable(mid) && $stable(flags) &&
          $stable(data_q) && $stable(cfgb_q)));
   // R9
   quiet_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && !(sel_data && in_test)) |=>
         ($stable(flags) && $stable(head) && $stable(mode)));
   // R6
   plain_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel_data && !in_test) |=> ($stable(flags) && $stable(head)));
   // R3
   mode_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel_ctrl && wr_data[7:5] != mode) |=> flags == FL_EMPTY);
   // R3
   same_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel_ctrl && wr_data[7:5] == mode) |=> $stable(flags));
endmodule

// File: tb/xcr_bank_test.sv
module xcr_bank_test;
   localparam int DEPTH = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [2:0] mode_o;

   int vectors = 0;
   int misses  = 0;
   bit done    = 0;

   // behavioural reference state
   int m_mode = 0, m_mid = 0, m_flags = 1, m_wp = 0, m_rp = 0;
   int m_data = 0, m_cfgb = 0;
   int m_fifo [DEPTH];

   always #5 clk = ~clk;

   xcr_bank uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .addr    (addr),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .mode_o  (mode_o)
   );

   function automatic int expect_rd(input int a);
      case (a)
         0:       return (m_mode == 6) ? m_fifo[m_rp] : m_data;
         1:       return m_cfgb;
         2:       return (m_mode << 5) | (m_mid << 2) | m_flags;
         default: return 255;
      endcase
   endfunction

   task automatic compare(input string req);
      int exp_rd;
      exp_rd = expect_rd(int'(addr));
      vectors++;
      if (int'(rd_data) != exp_rd || int'(mode_o) != m_mode) begin
         misses++;
         $display("FAIL %s addr=%0d rd_data=%02h exp=%02h mode=%0d exp=%0d",
                  req, addr, rd_data, exp_rd[7:0], mode_o, m_mode);
      end
   endtask

   task automatic model_step(input bit w, input bit r, input int a, input int d);
      if (w) begin
         case (a)
            0: if (m_mode == 6) begin
                  m_fifo[m_wp] = d;
                  m_wp++;
                  if (m_wp == DEPTH) begin m_wp = 0; m_flags = 2; end
                  else m_flags = 0;
               end else m_data = d;
            1: m_cfgb = d;
            2: begin
                  if (((d >> 5) & 7) != m_mode) begin
                     m_wp = 0; m_rp = 0; m_flags = 1;
                  end
                  m_mode = (d >> 5) & 7;
                  m_mid  = (d >> 2) & 7;
               end
            default: ;
         endcase
      end else if (r && a == 0 && m_mode == 6) begin
         m_rp++;
         if (m_rp == DEPTH) m_rp = 0;
         m_flags = (m_rp == m_wp) ? 1 : 0;
      end
   endtask

   // one bus cycle: drive after falling edge, compare before rising edge
   task automatic cyc(input bit w, input bit r, input int a, input int d,
                      input string req);
      @(negedge clk);
      wr_en = w; rd_en = r; addr = 3'(a); wr_data = 8'(d);
      #2 compare(req);
      @(posedge clk);
      #1 model_step(w, r, a, d);
   endtask

   task automatic wr(input int a, input int d, input string req);
      cyc(1'b1, 1'b0, a, d, req);
   endtask
   task automatic rd(input int a, input string req);
      cyc(1'b0, 1'b1, a, 0, req);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) m_fifo[i] = 0;
      repeat (3) @(negedge clk);
      addr = 3'd2;
      #2 compare("R1 reset ctrl");
      rst_n = 1'b1;
      // R1 reset values at every mapped offset
      rd(0, "R1"); rd(1, "R1"); rd(2, "R1");
      // R7 configuration byte
      wr(1, 8'hA5, "R7"); rd(1, "R7");
      // R6 plain data register in compatibility mode
      wr(0, 8'h3C, "R6"); rd(0, "R6"); rd(2, "R6 flags");
      // R8 upper offsets
      for (int a = 3; a < 8; a++) wr(a, 8'h00, "R8");
      for (int a = 3; a < 8; a++) rd(a, "R8");
      rd(0, "R8 data kept"); rd(1, "R8 cfgb kept"); rd(2, "R8 ctrl kept");
      // R2 full control write, low bits ignored
      wr(2, 8'hFF, "R2"); rd(2, "R2");
      wr(2, 8'h4A, "R2"); rd(2, "R2");
      // enter FIFO-test mode
      wr(2, 8'hC0, "R3"); rd(2, "R3");
      // R4 push one, some data
      wr(0, 8'h11, "R4"); rd(2, "R4");
      // R9 reads elsewhere change nothing
      rd(1, "R9"); rd(2, "R9"); rd(5, "R9"); rd(2, "R9");
      // R4 push to full
      wr(0, 8'h22, "R4"); rd(2, "R4 full");
      // R3 same-mode write keeps FIFO
      wr(2, 8'hDB, "R3 same mode"); rd(2, "R3"); 
      // R5 pops
      rd(0, "R5"); rd(2, "R5"); rd(0, "R5"); rd(2, "R5 empty");
      // R5 underrun pop, wraparound
      rd(0, "R5 underrun"); rd(2, "R5");
      // R4 overrun: three pushes
      wr(0, 8'h33, "R4"); wr(0, 8'h44, "R4"); wr(0, 8'h55, "R4 overrun");
      rd(2, "R4"); rd(0, "R5"); rd(0, "R5"); rd(2, "R5");
      // R6 test mode leaves plain register intact; R3 flush on change
      wr(0, 8'h66, "R4"); rd(2, "R4");
      wr(2, 8'h20, "R3 flush"); rd(2, "R3"); rd(0, "R6 plain back");
      wr(0, 8'h77, "R6"); rd(0, "R6"); rd(2, "R6 flags");
      // back to test mode: FIFO empty after flush
      wr(2, 8'hC0, "R3"); rd(2, "R3"); rd(0, "R5");
      // R10 flags walk through all codes again
      wr(0, 8'h88, "R10"); wr(0, 8'h99, "R10"); rd(2, "R10");
      rd(0, "R10"); rd(0, "R10"); rd(2, "R10");
      @(negedge clk);
      wr_en = 0; rd_en = 0;
      finish_run();
   end

   initial begin
      #2000000;
      misses++;
      $display("FAIL watchdog expired before end of sequence");
      finish_run();
   end
endmodule